// File: doc/BRIEF.md
# GPIO Bit-Bang Bridge

This block is a small register file on a 32-bit word bus that turns processor writes into the control wires of a NAND flash and a serial temperature-style sensor. Two general ports, A and D, each hold a driven value, an output-enable mask and a data-in view. The remaining word slots of the window are plain scratch storage.

Software drives the NAND latch and select lines by writing port A's driven value. It polls the flash ready line through port A's data-in view. The sensor is clocked by toggling one bit of port D's driven value. Each write that flips that bit raises a one-cycle edge strobe, with the clock level and the outgoing serial bit held on their own pins. The sensor's returned serial bit is read back through port D's data-in view.

Top module: `gpio_bitbang_bridge`

## Requirements
- R1: After reset every register slot reads zero, the NAND lines and sensor lines are low and the edge strobe is idle.
- R2: A full-word write to any slot other than the two data-in slots, inside the window, is returned unchanged by a full-word read of the same slot. Slot index is the byte address shifted right by two.
- R3: A read of slot 0x01 returns (slot 0x00 AND slot 0x02) with the NAND ready input ORed into bit 7.
- R4: After a full-word write to slot 0x00, the NAND address-latch output equals bit 6, command-latch equals bit 5 and chip-enable equals bit 4 of the written word, from the next cycle on.
- R5: A read of slot 0x11 returns (slot 0x10 AND slot 0x12) with the sensor return input ORed into bit 4.
- R6: A full-word write to slot 0x10 whose bit 1 differs from the stored bit 1 pulses the edge strobe high for exactly the next cycle. In that cycle the clock output carries the new bit 1 and the serial output carries the new bit 4.
- R7: A write to slot 0x10 that leaves bit 1 unchanged gives no strobe, but still updates the serial output to the new bit 4.
- R8: A write whose byte enables are not all four set changes nothing, and a read whose byte enables are not all four set returns zero.
- R9: Writes to the data-in slots 0x01 and 0x11 have no effect on their readback.
- R10: The window covers 23 slots (0x5C bytes); a write at or above it is dropped and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 7 | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as bus_rd |
| nand_ale | output | 1 | NAND address latch |
| nand_cle | output | 1 | NAND command latch |
| nand_ce | output | 1 | NAND chip enable |
| nand_rdy | input | 1 | NAND ready |
| sens_clk | output | 1 | Sensor clock level |
| sens_stb | output | 1 | One-cycle sensor clock edge strobe |
| sens_mosi | output | 1 | Serial bit sent to the sensor |
| sens_miso | input | 1 | Serial bit returned by the sensor |

## Verification
One port D write can flip the clock bit and change the serial data bit at the same time. The bench makes such writes in both directions and checks, in the strobe cycle, that the clock and data pins already show the new word. Bit 4 of port D readback is shared by the masked driven value and the live sensor input. The bench sets the two sources against each other, one high and one low in each order, and expects the OR.

// File: rtl/gpio_bitbang_bridge.sv
`timescale 1ns/1ps
module gpio_bitbang_bridge #(
  parameter int ADDR_W   = 7,
  parameter int NSLOT    = 23,
  parameter int A_DOUT   = 'h00,
  parameter int A_DIN    = 'h01,
  parameter int A_OE     = 'h02,
  parameter int D_DOUT   = 'h10,
  parameter int D_DIN    = 'h11,
  parameter int D_OE     = 'h12,
  parameter int RDY_BIT  = 7,
  parameter int ALE_BIT  = 6,
  parameter int CLE_BIT  = 5,
  parameter int CE_BIT   = 4,
  parameter int SCK_BIT  = 1,
  parameter int SDAT_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic              nand_ce,
  input  logic              nand_rdy,
  output logic              sens_clk,
  output logic              sens_stb,
  output logic              sens_mosi,
  input  logic              sens_miso
);
  localparam int IDX_W = ADDR_W - 2;

  logic [31:0]      slot [NSLOT];
  logic [IDX_W-1:0] idx;
  logic             full, in_win, wr_ok;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign full   = (bus_be == 4'hF);
  assign in_win = (int'(idx) < NSLOT);
  assign wr_ok  = bus_wr && full && in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) slot[i] <= '0;
      sens_stb <= 1'b0;
    end else begin
      sens_stb <= wr_ok && (int'(idx) == D_DOUT) &&
                  (bus_wdata[SCK_BIT] != slot[D_DOUT][SCK_BIT]);
      if (wr_ok && int'(idx) != A_DIN && int'(idx) != D_DIN)
        slot[idx] <= bus_wdata;
    end
  end

  assign nand_ale  = slot[A_DOUT][ALE_BIT];
  assign nand_cle  = slot[A_DOUT][CLE_BIT];
  assign nand_ce   = slot[A_DOUT][CE_BIT];
  assign sens_clk  = slot[D_DOUT][SCK_BIT];
  assign sens_mosi = slot[D_DOUT][SDAT_BIT];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && full && in_win) begin
      if (int'(idx) == A_DIN) begin
        bus_rdata = slot[A_DOUT] & slot[A_OE];
        bus_rdata[RDY_BIT] = bus_rdata[RDY_BIT] | nand_rdy;
      end else if (int'(idx) == D_DIN) begin
        bus_rdata = slot[D_DOUT] & slot[D_OE];
        bus_rdata[SDAT_BIT] = bus_rdata[SDAT_BIT] | sens_miso;
      end else begin
        bus_rdata = slot[idx];
      end
    end
  end
endmodule

// File: rtl/gpio_bitbang_bridge_chk.sv
`timescale 1ns/1ps
module gpio_bitbang_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [6:0]  bus_addr,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        nand_ale,
  input logic        nand_cle,
  input logic        nand_ce,
  input logic        sens_clk,
  input logic        sens_stb,
  input logic        sens_mosi
);
  // R4
  nand_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_be == 4'hF && bus_addr[6:2] == 5'h00) |->
      {nand_ale, nand_cle, nand_ce} == $past(bus_wdata[6:4]));

  // R6
  stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sens_stb |-> $past(bus_wr && bus_be == 4'hF && bus_addr[6:2] == 5'h10));

  // R6
  stb_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sens_stb |-> (sens_clk != $past(sens_clk)) && (sens_mosi == $past(bus_wdata[4])));

  // R7
  no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_clk == $past(sens_clk)) |-> !sens_stb);

  // R8
  part_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_be != 4'hF) |-> bus_rdata == 32'h0);

  // R10
  window_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[6:2] >= 5'd23) |-> bus_rdata == 32'h0);
endmodule

bind gpio_bitbang_bridge gpio_bitbang_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .nand_ale(nand_ale), .nand_cle(nand_cle),
  .nand_ce(nand_ce), .sens_clk(sens_clk), .sens_stb(sens_stb),
  .sens_mosi(sens_mosi)
);

// File: tb/sim_gpio_bitbang_bridge.sv
`timescale 1ns/1ps
module sim_gpio_bitbang_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        nand_ale, nand_cle, nand_ce;
  logic        nand_rdy = 1'b0;
  logic        sens_clk, sens_stb, sens_mosi;
  logic        sens_miso = 1'b0;

  int checks = 0, errors = 0;
  logic last_stb;

  always #4 clk = ~clk;

  gpio_bitbang_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .nand_ale(nand_ale), .nand_cle(nand_cle),
    .nand_ce(nand_ce), .nand_rdy(nand_rdy), .sens_clk(sens_clk),
    .sens_stb(sens_stb), .sens_mosi(sens_mosi), .sens_miso(sens_miso)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    last_stb = sens_stb;
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd32(input logic [6:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_be = be;
    #1 d = bus_rdata;
    bus_rd = 1'b0; bus_be = 4'h0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 23; i++) begin
      rd32(7'(i * 4), v);
      check("R1 slot", v, 32'h0);
    end
    check("R1 lines", {29'h0, nand_ale, nand_cle, nand_ce}, 32'h0);
    check("R1 sensor", {29'h0, sens_clk, sens_stb, sens_mosi}, 32'h0);
  endtask

  task automatic t_store();
    logic [31:0] v;
    wr32(7'h0C, 32'h5555AAAA); rd32(7'h0C, v); check("R2 slot3", v, 32'h5555AAAA);
    wr32(7'h58, 32'hCAFE0001); rd32(7'h58, v); check("R2 slot22", v, 32'hCAFE0001);
    wr32(7'h0E, 32'h01234567); rd32(7'h0C, v); check("R2 low addr bits", v, 32'h01234567);
  endtask

  task automatic t_porta();
    logic [31:0] v;
    wr32(7'h00, 32'h000000F3);
    check("R4 ale", {31'h0, nand_ale}, 32'h1);
    check("R4 cle", {31'h0, nand_cle}, 32'h1);
    check("R4 ce",  {31'h0, nand_ce},  32'h1);
    wr32(7'h08, 32'h00000F0F);
    nand_rdy = 1'b1; rd32(7'h04, v); check("R3 rdy high", v, 32'h00000083);
    nand_rdy = 1'b0; rd32(7'h04, v); check("R3 rdy low", v, 32'h00000003);
    wr32(7'h00, 32'h00000040);
    check("R4 ale only", {29'h0, nand_ale, nand_cle, nand_ce}, 32'h4);
    wr32(7'h00, 32'h00000030);
    check("R4 cle ce", {29'h0, nand_ale, nand_cle, nand_ce}, 32'h3);
    wr32(7'h04, 32'hFFFFFFFF);
    rd32(7'h04, v); check("R9 A din", v, 32'h00000000);
    check("R9 lines kept", {29'h0, nand_ale, nand_cle, nand_ce}, 32'h3);
  endtask

  task automatic t_strobe();
    wr32(7'h40, 32'h00000012);
    check("R6 rise stb", {31'h0, last_stb}, 32'h1);
    check("R6 rise pins", {30'h0, sens_clk, sens_mosi}, 32'h3);
    @(negedge clk);
    check("R6 single cycle", {31'h0, sens_stb}, 32'h0);
    wr32(7'h40, 32'h00000002);
    check("R7 no stb", {31'h0, last_stb}, 32'h0);
    check("R7 mosi update", {30'h0, sens_clk, sens_mosi}, 32'h2);
    wr32(7'h40, 32'h00000010);
    check("R6 fall stb", {31'h0, last_stb}, 32'h1);
    check("R6 fall pins", {30'h0, sens_clk, sens_mosi}, 32'h1);
  endtask

  task automatic t_portd();
    logic [31:0] v;
    wr32(7'h40, 32'h00000012);
    wr32(7'h48, 32'h00000002);
    sens_miso = 1'b1; rd32(7'h44, v); check("R5 miso high", v, 32'h00000012);
    sens_miso = 1'b0; rd32(7'h44, v); check("R5 miso low", v, 32'h00000002);
    wr32(7'h48, 32'h00000012);
    rd32(7'h44, v); check("R5 driven bit4", v, 32'h00000012);
    wr32(7'h44, 32'h0);
    rd32(7'h44, v); check("R9 D din", v, 32'h00000012);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    wr32(7'h0C, 32'h5555AAAA);
    wr32(7'h0C, 32'h0000DEAD, 4'h3);
    rd32(7'h0C, v); check("R8 partial write", v, 32'h5555AAAA);
    rd32(7'h0C, v, 4'h1); check("R8 partial read", v, 32'h0);
    wr32(7'h40, 32'h00000000, 4'h7);
    check("R8 partial no stb", {31'h0, last_stb}, 32'h0);
  endtask

  task automatic t_window();
    logic [31:0] v;
    wr32(7'h5C, 32'hFFFF0000);
    rd32(7'h5C, v); check("R10 first outside", v, 32'h0);
    rd32(7'h7C, v); check("R10 top", v, 32'h0);
    rd32(7'h58, v); check("R10 last inside", v, 32'hCAFE0001);
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_store();
    t_porta();
    t_strobe();
    t_portd();
    t_partial();
    t_window();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule